// File: doc/BRIEF.md
# Chip-Select Bus Cycle Controller

This block runs external bus cycles for a set of programmable chip-select regions that each front a 16-bit memory or peripheral. An upstream decoder compares the request address against each region's base and mask and hands the block a one-hot hit vector together with a 32-bit internal request. The block drops the matching chip-select line and moves data over the upper half of a 32-bit external data bus. It ends every beat either by timing a programmed number of wait cycles and raising its own transfer acknowledge, or by waiting for an acknowledge from the device.

Each region has its own 16-bit control word. The word holds a wait count, an auto-acknowledge enable, a port-size code, and two burst enables, one for reads and one for writes. A 32-bit access to the 16-bit port takes two beats. When the burst enable for that direction is set, both beats run under one unbroken chip select. When it is clear, the access becomes two separate cycles with an idle cycle between them. Byte and word accesses take a single beat.

Top module: `cs_cycle_ctrl`

## Requirements
- R1: After reset every region's control word reads back 0. Written control words keep only the wait count (bits 13:10), the auto-acknowledge enable (bit 8), the port size (bits 7:6), the burst-read enable (bit 4) and the burst-write enable (bit 3). Every other bit reads back as 0.
- R2: With auto-acknowledge set, each beat holds its chip select for exactly waits+1 cycles. The internal acknowledge `int_ta` pulses in the last of those cycles. The external acknowledge input has no effect.
- R3: With auto-acknowledge clear, `int_ta` never rises. A beat ends in the cycle `ext_ack` is high, whatever the wait count is.
- R4: Data is driven from, and sampled on, external lines 31:16 only, and lines 15:0 of `ext_dout` stay 0. `ext_addr` carries the request address without bit 0, so it is the 16-bit word index.
- R5: Request size code 00 (byte) and code 01 (word) complete in one beat. Read data from such a beat is returned in `req_rdata[15:0]`, with the upper half set to 0.
- R6: A 32-bit read (size code 1x) with burst-read clear runs as two beats. The first beat carries the most significant word at word index addr[AW-1:1]. The second beat is at that index plus 1. Every chip select is high for at least one cycle between the two beats.
- R7: A 32-bit read with burst-read set runs as two beats with the chip select held low continuously from the first beat to the end of the second.
- R8: A 32-bit write splits into two beats or bursts according to the burst-write bit alone, independent of the burst-read bit. The first beat drives data bits 31:16 and the second drives bits 15:0.
- R9: `req_done` pulses for exactly one cycle, in the cycle after the final beat's acknowledge. For a 32-bit read, `req_rdata` then holds {first beat word, second beat word}.
- R10: Only the chip select of the hit region is ever low, and at most one line is low at a time. `ext_rd` is 1 during read beats and 0 during write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | $clog2(NUM_CS) | Region selected for control write/read |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word of the selected region |
| req_valid | input | 1 | Internal request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_hit | input | NUM_CS | One-hot region hit from the address decoder |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 1x 32-bit |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 32 | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Assembled read data |
| ext_cs_n | output | NUM_CS | Active-low chip selects |
| ext_addr | output | AW-1 | External word address (address bit 0 dropped) |
| ext_rd | output | 1 | 1 = read cycle |
| ext_doe | output | 1 | External data output enable |
| ext_dout | output | 32 | External data out, valid on 31:16 |
| ext_din | input | 32 | External data in, sampled on 31:16 |
| ext_ack | input | 1 | External transfer acknowledge |
| int_ta | output | 1 | Internal transfer acknowledge |

## Verification
A wrong wait counter shows up as a beat whose chip-select run is one cycle longer or shorter than waits+1. It also shows as `int_ta` in a region with auto-acknowledge clear, and both appear within the beat where the error occurs. A wrong beat index or burst decision appears at the second beat. It shows as a misplaced `ext_addr`, swapped write halves, or a chip-select gap that is missing or extra. A bad read capture is visible only in `req_rdata`, one cycle after the final acknowledge, when `req_done` pulses.

// File: rtl/cs_ctrl_pkg.sv
package cs_ctrl_pkg;
  localparam int WAIT_W = 4;
  localparam logic [15:0] CFG_KEEP = 16'h3DD8;

  typedef struct packed {
    logic [WAIT_W-1:0] waits;
    logic              auto_ack;
    logic [1:0]        psize;
    logic              burst_rd;
    logic              burst_wr;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_GAP, ST_FINISH} cs_state_t;

  function automatic cs_cfg_t cfg_unpack(input logic [15:0] w);
    cs_cfg_t c;
    c.waits    = w[13:10];
    c.auto_ack = w[8];
    c.psize    = w[7:6];
    c.burst_rd = w[4];
    c.burst_wr = w[3];
    return c;
  endfunction

  function automatic logic use_burst(input logic is_long, input logic wr, input cs_cfg_t c);
    return is_long && (wr ? c.burst_wr : c.burst_rd);
  endfunction

  function automatic logic [15:0] beat_word(input logic is_long, input logic beat, input logic [31:0] d);
    return (is_long && !beat) ? d[31:16] : d[15:0];
  endfunction
endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank #(
  parameter int NUM_CS = 4,
  localparam int SELW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SELW-1:0]         cfg_sel,
  input  logic [15:0]             cfg_wdata,
  output logic [15:0]             cfg_rdata,
  output logic [NUM_CS-1:0][15:0] cfg_all
);
  import cs_ctrl_pkg::*;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_all[i] <= '0;
      else if (cfg_we && (int'(cfg_sel) == i))
        cfg_all[i] <= cfg_wdata & CFG_KEEP;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (int'(cfg_sel) == i) cfg_rdata = cfg_all[i];
  end

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~CFG_KEEP) == 16'h0);
endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [WW-1:0] waits,
  input  logic          auto_ack,
  input  logic          ext_ack,
  output logic          int_ta,
  output logic          beat_ack
);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || beat_ack)
      cnt <= '0;
    else if (cnt != '1)
      cnt <= cnt + 1'b1;
  end

  assign int_ta   = run && auto_ack && (cnt == waits);
  assign beat_ack = auto_ack ? int_ta : (run && ext_ack);

  // R3
  no_int_ta_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ta |-> auto_ack);
  // R2
  ta_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ta |-> run);
endmodule

// File: rtl/cs_cycle_ctrl.sv
module cs_cycle_ctrl #(
  parameter int NUM_CS = 4,
  parameter int AW     = 24,
  localparam int SELW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SELW-1:0]   cfg_sel,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NUM_CS-1:0] req_hit,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_done,
  output logic [31:0]       req_rdata,
  output logic [NUM_CS-1:0] ext_cs_n,
  output logic [AW-2:0]     ext_addr,
  output logic              ext_rd,
  output logic              ext_doe,
  output logic [31:0]       ext_dout,
  input  logic [31:0]       ext_din,
  input  logic              ext_ack,
  output logic              int_ta
);
  import cs_ctrl_pkg::*;

  logic [NUM_CS-1:0][15:0] cfg_all;
  cs_state_t       state;
  logic [SELW-1:0] sel, hit_idx;
  logic            wr, lng, beat;
  logic [AW-2:0]   widx;
  logic [31:0]     wdat;
  logic [15:0]     rd_hi;
  cs_cfg_t         cfg_act;
  logic            burst, in_access, in_gap, beat_ack, accept, last_beat;

  cs_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_all(cfg_all));

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (req_hit[i]) hit_idx = SELW'(i);
  end

  assign cfg_act   = cfg_unpack(cfg_all[sel]);
  assign burst     = use_burst(lng, wr, cfg_act);
  assign in_access = (state == ST_ACCESS);
  assign in_gap    = (state == ST_GAP);
  assign accept    = (state == ST_IDLE) && req_valid && (|req_hit);
  assign last_beat = !lng || beat;

  cs_wait_timer #(.WW(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_access), .waits(cfg_act.waits),
    .auto_ack(cfg_act.auto_ack), .ext_ack(ext_ack),
    .int_ta(int_ta), .beat_ack(beat_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; sel <= '0; wr <= 1'b0; lng <= 1'b0; beat <= 1'b0;
      widx <= '0; wdat <= '0; rd_hi <= '0; req_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          sel  <= hit_idx;
          wr   <= req_write;
          lng  <= req_size[1];
          widx <= req_addr[AW-1:1];
          wdat <= req_wdata;
          beat <= 1'b0;
          state <= ST_ACCESS;
        end
        ST_ACCESS: if (beat_ack) begin
          if (!wr) begin
            if (lng && !beat) rd_hi <= ext_din[31:16];
            else req_rdata <= lng ? {rd_hi, ext_din[31:16]} : {16'h0, ext_din[31:16]};
          end
          if (last_beat) state <= ST_FINISH;
          else begin
            beat  <= 1'b1;
            state <= burst ? ST_ACCESS : ST_GAP;
          end
        end
        ST_GAP:    state <= ST_ACCESS;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign ext_cs_n[i] = !(in_access && (int'(sel) == i));
  end

  assign req_ready = (state == ST_IDLE);
  assign req_done  = (state == ST_FINISH);
  assign ext_addr  = widx + {{(AW-2){1'b0}}, beat};
  assign ext_rd    = !(in_access && wr);
  assign ext_doe   = in_access && wr;
  assign ext_dout  = ext_doe ? {beat_word(lng, beat, wdat), 16'h0} : 32'h0;

  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));
  // R6
  gap_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (&ext_cs_n));
  // R9
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> $past(beat_ack));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  // R4
  low_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_dout[15:0] == 16'h0);
endmodule

// File: tb/cs_cycle_ctrl_test.sv
module cs_cycle_ctrl_test;
  localparam int NCS = 4;
  localparam int AW  = 24;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready, req_write = 0, req_done;
  logic [NCS-1:0] req_hit = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0, req_rdata;
  logic [NCS-1:0] ext_cs_n;
  logic [AW-2:0] ext_addr;
  logic ext_rd, ext_doe, int_ta;
  logic [31:0] ext_dout, ext_din = 0;
  logic ext_ack = 0;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  cs_cycle_ctrl #(.NUM_CS(NCS), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_hit(req_hit), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .ext_cs_n(ext_cs_n),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_doe(ext_doe),
    .ext_dout(ext_dout), .ext_din(ext_din), .ext_ack(ext_ack), .int_ta(int_ta));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] keep_bits(input logic [15:0] w);
    return {2'b00, w[13:10], 1'b0, w[8], w[7:6], 1'b0, w[4], w[3], 3'b000};
  endfunction

  function automatic logic [15:0] word_of(input bit lng, input int b, input logic [31:0] d);
    if (lng && b == 0) return d[31:16];
    return d[15:0];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_txn(input int rg, input bit wr, input logic [1:0] sz,
                         input logic [AW-1:0] addr, input logic [31:0] data,
                         input logic [3:0] ws, input bit au, input bit bsr,
                         input bit bsw, input logic [1:0] ps, input int dly);
    bit lng, brst, gap, done;
    int nb, b, cur_len, last_ack;
    logic [15:0] w;
    string gtag;
    lng  = sz[1];
    nb   = lng ? 2 : 1;
    brst = lng && (wr ? bsw : bsr);
    // program the region with reserved bits set
    w = {2'b11, ws, 1'b1, au, ps, 1'b1, bsr, bsw, 3'b111};
    cfg_we = 1; cfg_sel = 2'(rg); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_rdata == keep_bits(w), "R1 cfg readback", {16'h0, cfg_rdata}, {16'h0, keep_bits(w)});
    chk(req_ready == 1'b1, "R9 ready when idle", {31'h0, req_ready}, 32'h1);
    req_valid = 1; req_hit = NCS'(1 << rg); req_write = wr; req_size = sz;
    req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 0; req_hit = 0;
    b = 0; cur_len = 0; last_ack = -10; gap = 0; done = 0;
    for (int t = 0; t < 300 && !done; t++) begin
      if (ext_cs_n != '1) begin
        bit ackn;
        chk(ext_cs_n == ~NCS'(1 << rg), "R10 cs select", {28'h0, ext_cs_n}, {28'h0, ~NCS'(1 << rg)});
        cur_len++;
        ext_din = {word_of(lng, b, data), 16'($urandom)};
        ackn = au ? int_ta : (cur_len == dly + 1);
        ext_ack = au ? 1'($urandom) : ackn;
        if (ackn) begin
          if (au) chk(cur_len == ws + 1, "R2 beat length", cur_len, ws + 1);
          else begin
            chk(int_ta == 1'b0, "R3 no internal ack", {31'h0, int_ta}, 32'h0);
            chk(cur_len == dly + 1, "R3 ext ack beat", cur_len, dly + 1);
          end
          chk(ext_addr == addr[AW-1:1] + 23'(b), "R4 word address",
              {9'h0, ext_addr}, {9'h0, addr[AW-1:1] + 23'(b)});
          chk(ext_rd == !wr, "R10 direction", {31'h0, ext_rd}, {31'h0, !wr});
          if (wr) chk(ext_dout == {word_of(lng, b, data), 16'h0}, "R8 write lanes",
                      ext_dout, {word_of(lng, b, data), 16'h0});
          cur_len = 0; b++; last_ack = t;
        end
      end else begin
        ext_ack = 0;
        if (b > 0 && b < nb) gap = 1;
        if (req_done) begin
          done = 1;
          chk(t == last_ack + 1, "R9 done timing", t, last_ack + 1);
          chk(b == nb, "R5 beat count", b, nb);
          if (!wr) chk(req_rdata == (lng ? data : {16'h0, data[15:0]}), "R9 read data",
                       req_rdata, lng ? data : {16'h0, data[15:0]});
        end
      end
      @(negedge clk);
    end
    ext_ack = 0;
    chk(done, "R9 done seen", {31'h0, done}, 32'h1);
    chk(req_done == 1'b0, "R9 single pulse", {31'h0, req_done}, 32'h0);
    gtag = wr ? "R8 split gap" : (brst ? "R7 burst no gap" : "R6 split gap");
    chk(gap == (nb == 2 && !brst), gtag, {31'h0, gap}, {31'h0, (nb == 2 && !brst)});
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NCS; i++) begin
      cfg_sel = 2'(i);
      #0.1;
      chk(cfg_rdata == 16'h0, "R1 reset value", {16'h0, cfg_rdata}, 32'h0);
    end
    chk(ext_cs_n == '1, "R10 idle cs", {28'h0, ext_cs_n}, 32'hF);
    chk(req_done == 1'b0, "R9 idle done", {31'h0, req_done}, 32'h0);
    // directed corners
    run_txn(0, 0, 2'b10, 24'h001230, 32'hA1B2C3D4, 4'd15, 1, 0, 1, 2'b10, 0); // R6 max waits
    run_txn(1, 0, 2'b10, 24'h004440, 32'h13572468, 4'd15, 0, 1, 0, 2'b11, 0); // R3 R7 waits ignored
    run_txn(2, 1, 2'b10, 24'h000100, 32'hDEADBEEF, 4'd2, 1, 0, 1, 2'b10, 0);  // R8 burst write
    run_txn(3, 1, 2'b10, 24'h000200, 32'hCAFEF00D, 4'd0, 1, 1, 0, 2'b10, 0);  // R8 split write
    run_txn(0, 0, 2'b00, 24'h000011, 32'h0000ABCD, 4'd0, 1, 1, 1, 2'b10, 0);  // R5 byte read
    run_txn(1, 1, 2'b01, 24'h000022, 32'h00005A5A, 4'd1, 0, 0, 0, 2'b11, 3);  // R5 word write
    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      run_txn(int'($urandom_range(0, NCS - 1)), 1'($urandom), sz,
              AW'($urandom) & ~AW'(sz[1] ? 3 : 0), $urandom,
              4'($urandom_range(0, 6)), 1'($urandom), 1'($urandom), 1'($urandom),
              {1'b1, 1'($urandom)}, int'($urandom_range(0, 4)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule